// File: doc/BRIEF.md
# Program-memory write control register

This block is an 8-bit control and status register on a microcontroller's special-function bus. It decides where external-data store operations go. Its program-write select bit sends them to program flash at the data-pointer address instead of data RAM. The register also arms a one-shot mass erase, holds a security latch that software can only set, and shows whether the preboot sequence is running. The flash array and its timing live elsewhere. This block only supplies the control levels and reacts to the done pulses that the flash controller returns.

Each bit follows its own rule. The program-write select clears itself once a flash byte has been written, and software cannot change it while interrupts are globally enabled. The mass-erase arm clears itself when the erase completes, so it has to be written again before each new erase. The security latch stays set until chip reset. The preboot bit is a live status input and cannot be written. Bits 2 to 5 are not used.

Top module: `pgm_wr_ctl`

## Requirements
- R1: After reset, bits 6..0 of `reg_q` are 0, and `pgm_sel`, `erase_arm` and `secure_on` are low.
- R2: A write takes effect only when `wr_en` is high and `wr_addr` equals 0xB2. A write to any other address changes nothing.
- R3: Bit 0 is the program-write select, and `pgm_sel` always equals it. With `int_en` low, an accepted write loads `wr_data[0]` into bit 0 from the next clock edge.
- R4: While `int_en` is high, writes leave bit 0 unchanged.
- R5: A `byte_done` pulse clears bit 0 at the next edge. This also holds when a write in the same cycle tries to set bit 0.
- R6: Bit 1 is the mass-erase arm, and `erase_arm` always equals it. An accepted write loads `wr_data[1]` into bit 1 whatever `int_en` is.
- R7: An `erase_done` pulse clears bit 1 at the next edge, even when a write in the same cycle sets it. A later erase needs a fresh write of 1.
- R8: Bit 6 is the security latch, and `secure_on` always equals it. Writing 1 sets it and writing 0 has no effect. Only reset clears it.
- R9: Bit 7 of `reg_q` follows `preboot_in` in the same cycle, and writes do not affect it.
- R10: Bits 5..2 of `reg_q` always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| wr_en | input | 1 | Special-function register write strobe |
| wr_addr | input | 8 | Special-function write address |
| wr_data | input | 8 | Write data |
| int_en | input | 1 | Global interrupt-enable state |
| byte_done | input | 1 | Pulse: one flash byte has been written |
| erase_done | input | 1 | Pulse: mass erase has finished |
| preboot_in | input | 1 | Preboot sequence active |
| reg_q | output | 8 | Current register value |
| pgm_sel | output | 1 | Route external-data stores to program flash |
| erase_arm | output | 1 | Mass erase enabled |
| secure_on | output | 1 | Block external reads of flash and engine program RAM |

## Verification
Register bits driven by writes and done pulses change at the first rising edge after the stimulus, so their result is due one cycle later. The preboot bit has no latency and must already match in the cycle it is driven. The driver sets inputs on the falling edge and, just after the rising edge that captures them, queues the value the requirements predict. The monitor compares shortly after that same edge, while the inputs are still held, so the combinational preboot bit and the registered bits are both checked in a stable window.

// File: rtl/pgm_wr_ctl_pkg.sv
package pgm_wr_ctl_pkg;

   // Kind of storage behind each register bit
   typedef enum logic [1:0] {
      PWC_ZERO = 2'd0,   // unused, reads 0
      PWC_CLR  = 2'd1,   // writable, cleared by a done event
      PWC_LOCK = 2'd2,   // set-only latch
      PWC_STAT = 2'd3    // live status input
   } pwc_kind_e;

   function automatic pwc_kind_e pwc_kind(input int pos, input int b_pgm,
                                          input int b_erase, input int b_lock,
                                          input int b_boot);
      if (pos == b_pgm || pos == b_erase) return PWC_CLR;
      if (pos == b_lock)                  return PWC_LOCK;
      if (pos == b_boot)                  return PWC_STAT;
      return PWC_ZERO;
   endfunction

endpackage

// File: rtl/pwc_decode.sv
module pwc_decode #(
   parameter int          ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 'hB2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("pwc_decode: ADDR_W out of range");
   end
   if (ADDR_W < 32 && REG_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_addr
      $error("pwc_decode: REG_ADDR does not fit ADDR_W");
   end

   assign hit = wr_en && (wr_addr == MATCH);
endmodule

// File: rtl/pwc_clr_cell.sv
module pwc_clr_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ok,
   input  logic wr_bit,
   input  logic clr_evt,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (clr_evt) q <= 1'b0;
      else if (wr_ok)   q <= wr_bit;
   end

   // R5 R7
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> !q);

   // R3 R6
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !clr_evt) |=> (q == $past(wr_bit)));
endmodule

// File: rtl/pwc_lock_cell.sv
module pwc_lock_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_req) q <= 1'b1;
   end

   // R8
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q |=> q);

   // R8
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> q);
endmodule

// File: rtl/pgm_wr_ctl.sv
module pgm_wr_ctl
   import pgm_wr_ctl_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter int unsigned REG_ADDR  = 'hB2,
   parameter int          BIT_PGM   = 0,
   parameter int          BIT_ERASE = 1,
   parameter int          BIT_LOCK  = 6,
   parameter int          BIT_BOOT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              int_en,
   input  logic              byte_done,
   input  logic              erase_done,
   input  logic              preboot_in,
   output logic [DATA_W-1:0] reg_q,
   output logic              pgm_sel,
   output logic              erase_arm,
   output logic              secure_on
);
   localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'(1) << BIT_PGM) | (DATA_W'(1) << BIT_ERASE) | (DATA_W'(1) << BIT_LOCK);

   // elaboration checks on the bit map
   if (BIT_PGM >= DATA_W || BIT_ERASE >= DATA_W ||
       BIT_LOCK >= DATA_W || BIT_BOOT >= DATA_W) begin : g_bad_pos
      $error("pgm_wr_ctl: bit position beyond DATA_W");
   end
   if (BIT_PGM == BIT_ERASE || BIT_PGM == BIT_LOCK || BIT_PGM == BIT_BOOT ||
       BIT_ERASE == BIT_LOCK || BIT_ERASE == BIT_BOOT || BIT_LOCK == BIT_BOOT) begin : g_bad_map
      $error("pgm_wr_ctl: bit positions overlap");
   end

   logic hit;
   logic unused_wr_bits;

   pwc_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .hit    (hit)
   );

   assign unused_wr_bits = ^(wr_data & ~USED_MASK);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam pwc_kind_e KIND = pwc_kind(i, BIT_PGM, BIT_ERASE, BIT_LOCK, BIT_BOOT);
      if (KIND == PWC_CLR) begin : g_clr
         logic ok, clr;
         if (i == BIT_PGM) begin : g_pgm
            assign ok  = hit && !int_en;
            assign clr = byte_done;
         end else begin : g_erase
            assign ok  = hit;
            assign clr = erase_done;
         end
         pwc_clr_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ok  (ok),
            .wr_bit (wr_data[i]),
            .clr_evt(clr),
            .q      (reg_q[i])
         );
      end else if (KIND == PWC_LOCK) begin : g_lock
         pwc_lock_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_req(hit && wr_data[i]),
            .q      (reg_q[i])
         );
      end else if (KIND == PWC_STAT) begin : g_stat
         assign reg_q[i] = preboot_in;
      end else begin : g_zero
         assign reg_q[i] = 1'b0;
      end
   end

   assign pgm_sel   = reg_q[BIT_PGM];
   assign erase_arm = reg_q[BIT_ERASE];
   assign secure_on = reg_q[BIT_LOCK];

   // R4
   pgm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en && !byte_done) |=> $stable(pgm_sel));

   // R2
   miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !byte_done && !erase_done) |=> ($stable(pgm_sel) && $stable(erase_arm)));

   // R5
   pgm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !pgm_sel);
endmodule

// File: tb/pgm_wr_ctl_tb.sv
`timescale 1ns/1ps
module pgm_wr_ctl_tb;
   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, int_en = 0, byte_done = 0, erase_done = 0, preboot_in = 0;
   logic [7:0] wr_addr = 0, wr_data = 0;
   logic [7:0] reg_q;
   logic pgm_sel, erase_arm, secure_on;
   int total = 0, bad = 0;
   bit finished = 0;
   exp_t sb[$];
   logic m0 = 0, m1 = 0, m6 = 0;

   always #2.5 clk = ~clk;

   pgm_wr_ctl u_dut (.*);

   task automatic check(input logic [7:0] exp, input string tag);
      logic [10:0] act, want;
      act  = {pgm_sel, erase_arm, secure_on, reg_q};
      want = {exp[0], exp[1], exp[6], exp};
      total++;
      if (act !== want) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", tag, act, want);
      end
   endtask

   // driver: one cycle of stimulus, then queue the predicted result
   task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic ie, input logic bd, input logic ed,
                       input logic pb, input string tag);
      logic h;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; int_en = ie;
      byte_done = bd; erase_done = ed; preboot_in = pb;
      h  = we && (a == 8'hB2);
      m0 = bd ? 1'b0 : ((h && !ie) ? d[0] : m0);
      m1 = ed ? 1'b0 : (h ? d[1] : m1);
      m6 = m6 | (h && d[6]);
      @(posedge clk); #1;
      sb.push_back('{val: {pb, m6, 4'b0000, m1, m0}, tag: tag});
   endtask

   // monitor
   initial forever begin
      @(posedge clk); #2;
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.val, e.tag);
      end
   end

   initial begin
      #(5.0 * 5000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check(8'h00, "R1 reset");
      @(negedge clk) rst_n = 1'b1;
      step(0, 8'h00, 8'h00, 0, 0, 0, 0, "R1 idle after reset");
      step(1, 8'hB3, 8'hFF, 0, 0, 0, 0, "R2 wrong address ignored");
      step(0, 8'hB2, 8'hFF, 0, 0, 0, 0, "R2 no strobe ignored");
      step(1, 8'hB2, 8'h01, 0, 0, 0, 0, "R3 set pgm_sel");
      step(1, 8'hB2, 8'h00, 1, 0, 0, 0, "R4 clear blocked by int_en");
      step(0, 8'h00, 8'h00, 0, 1, 0, 0, "R5 byte_done clears");
      step(1, 8'hB2, 8'h01, 1, 0, 0, 0, "R4 set blocked by int_en");
      step(1, 8'hB2, 8'h01, 0, 1, 0, 0, "R5 byte_done beats write");
      step(1, 8'hB2, 8'h03, 1, 0, 0, 0, "R6 erase arm with int_en high");
      step(1, 8'hB2, 8'h00, 0, 0, 0, 0, "R6 write 0 disarms");
      step(1, 8'hB2, 8'h02, 0, 0, 0, 0, "R6 re-arm");
      step(0, 8'h00, 8'h00, 0, 0, 1, 0, "R7 erase_done clears");
      step(1, 8'hB2, 8'h02, 0, 0, 1, 0, "R7 erase_done beats write");
      step(0, 8'h00, 8'h00, 0, 0, 0, 0, "R7 stays clear");
      step(1, 8'hB2, 8'h3C, 0, 0, 0, 0, "R10 bits 5..2 read 0");
      step(1, 8'hB2, 8'h40, 0, 0, 0, 0, "R8 set latch");
      step(1, 8'hB2, 8'h00, 0, 0, 0, 0, "R8 write 0 no effect");
      step(0, 8'h00, 8'h00, 0, 0, 0, 1, "R9 preboot high");
      step(1, 8'hB2, 8'h00, 0, 0, 0, 1, "R9 write does not clear preboot");
      step(1, 8'hB2, 8'h80, 0, 0, 0, 0, "R9 write 1 does not set preboot");
      step(1, 8'hB2, 8'h03, 0, 0, 0, 0, "R3 R6 both set");
      @(negedge clk);
      wr_en = 0; rst_n = 1'b0;
      m0 = 0; m1 = 0; m6 = 0;
      #1 check(8'h00, "R8 reset clears latch");
      @(negedge clk) rst_n = 1'b1;
      step(0, 8'h00, 8'h00, 0, 0, 0, 0, "R8 stays clear after reset");
      repeat (2) @(posedge clk);
      #3;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule